// File: doc/BRIEF.md
# Default Control Endpoint Status Register

This block holds the one-byte control and status register for endpoint 0, the default control pipe of a USB device. Two parties write to it. The CPU writes through a byte-wide port. The serial engine raises single-cycle event strobes when a packet arrives, when the host acknowledges a transmitted packet, when the status stage completes, when a SETUP token arrives, when a control transfer ends early, and when it detects a protocol violation.

Each bit has its own access rule. Some bits can only be set by the CPU. One bit can only be cleared by the CPU. Some bits are read-only flags. Two write-only service bits let the CPU acknowledge an event without writing the flag itself.

The register also produces a stall indication. The serial engine uses it to answer tokens on endpoint 0 with a STALL handshake.

All flags update on the clock edge that samples a write or an event. The read data is a combinational view of the stored flags.

Top module: `ep0_ctrl_csr`

## Requirements
- R1: After reset the register reads 0x00 and `stall_o` is 0.
- R2: Bit 0 (received-ready) is set by `rx_done_i` and cleared by a write with bit 6 = 1. A CPU write to bit 0 itself has no effect.
- R3: Bit 1 (transmit-ready) is set by a write with bit 1 = 1. Writing 0 to bit 1 has no effect. `tx_ack_i` clears it. When a CPU set and `tx_ack_i` occur in the same cycle, the CPU set wins.
- R4: Bits 2 (CPU stall request) and 3 (last-data marker) are set by writing 1 and are unaffected by writing 0. Each is cleared by `status_done_i` or `setup_tok_i`. A CPU set in the same cycle as such a clear wins.
- R5: Bit 4 (forced stall) is set by `proto_err_i` and cleared by a write with bit 4 = 0. Writing 1 to bit 4 has no effect.
- R6: Bit 5 (early-end) is set by `setup_abort_i` and cleared by a write with bit 7 = 1. A CPU write to bit 5 itself has no effect.
- R7: Bits 7 and 6 always read 0.
- R8: `stall_o` is 1 exactly when bit 2 or bit 4 is 1.
- R9: When a hardware set of bit 0, 4 or 5 coincides with the CPU clear of the same bit, the bit ends up set.
- R10: A write or event takes effect at the clock edge that samples it. During the cycle of the write, `cpu_rdata_o` still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_wr_i | input | 1 | CPU write strobe, one cycle |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | Register read view |
| rx_done_i | input | 1 | OUT or SETUP packet received without error |
| tx_ack_i | input | 1 | Host acknowledged the IN packet |
| status_done_i | input | 1 | Status stage of the transfer completed |
| setup_tok_i | input | 1 | SETUP token arrived |
| setup_abort_i | input | 1 | Control transfer ended before its data length was moved |
| proto_err_i | input | 1 | Protocol violation; forces a stall |
| stall_o | output | 1 | Answer endpoint 0 tokens with STALL |

## Verification
The assertions assume that the event inputs and the write strobe are single-cycle pulses, sampled at the rising edge. They also assume that the write data is meaningful only while `cpu_wr_i` is high. Beyond that, the assertions allow any mix of events in one cycle.

The stimulus drives all inputs half a period away from the sampling edge and holds each for exactly one cycle. It deliberately stacks a CPU write on top of a hardware event in the same cycle, so that every set-versus-clear priority is exercised.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;
  localparam int CSR_W = 8;
  localparam int NFLAG = 6;

  // bit positions as decoded by firmware
  localparam int B_RX_RDY    = 0;
  localparam int B_TX_RDY    = 1;
  localparam int B_STALL_REQ = 2;
  localparam int B_LAST_DATA = 3;
  localparam int B_FORCE_STL = 4;
  localparam int B_EARLY_END = 5;
  localparam int B_SRV_RX    = 6;
  localparam int B_SRV_EARLY = 7;

  typedef struct packed {
    logic rx_done;
    logic tx_ack;
    logic status_done;
    logic setup_tok;
    logic setup_abort;
    logic proto_err;
  } ep0_evt_t;
endpackage

// File: rtl/ep0_csr_flag.sv
module ep0_csr_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= RST_VAL;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  // R9
  flag_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);

  // R10
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);

  // R10
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> q_o == $past(q_o));
endmodule

// File: rtl/ep0_csr_ctrl.sv
module ep0_csr_ctrl
  import ep0_csr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CSR_W-1:0] wdata_i,
  input  ep0_evt_t         evt_i,
  output logic [NFLAG-1:0] set_o,
  output logic [NFLAG-1:0] clr_o
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[B_RX_RDY], wdata_i[B_EARLY_END]};

  logic stage_end;
  assign stage_end = evt_i.status_done | evt_i.setup_tok;

  always_comb begin
    set_o = '0;
    clr_o = '0;
    // read-only flag, acked through service bit
    set_o[B_RX_RDY]    = evt_i.rx_done;
    clr_o[B_RX_RDY]    = wr_i & wdata_i[B_SRV_RX];
    // CPU set, hardware clear
    set_o[B_TX_RDY]    = wr_i & wdata_i[B_TX_RDY];
    clr_o[B_TX_RDY]    = evt_i.tx_ack;
    set_o[B_STALL_REQ] = wr_i & wdata_i[B_STALL_REQ];
    clr_o[B_STALL_REQ] = stage_end;
    set_o[B_LAST_DATA] = wr_i & wdata_i[B_LAST_DATA];
    clr_o[B_LAST_DATA] = stage_end;
    // hardware set, CPU clear by writing 0
    set_o[B_FORCE_STL] = evt_i.proto_err;
    clr_o[B_FORCE_STL] = wr_i & ~wdata_i[B_FORCE_STL];
    // read-only flag, acked through service bit
    set_o[B_EARLY_END] = evt_i.setup_abort;
    clr_o[B_EARLY_END] = wr_i & wdata_i[B_SRV_EARLY];
  end

  // R2
  rx_ack_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[B_SRV_RX]) |-> clr_o[B_RX_RDY]);

  // R5
  force_one_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdata_i[B_FORCE_STL] |-> !clr_o[B_FORCE_STL]);
endmodule

// File: rtl/ep0_csr_read.sv
module ep0_csr_read
  import ep0_csr_pkg::*;
(
  input  logic [NFLAG-1:0] flag_i,
  output logic [CSR_W-1:0] rdata_o,
  output logic             stall_o
);
  localparam int PAD_W = CSR_W - NFLAG;

  // service bits have no storage
  assign rdata_o = {{PAD_W{1'b0}}, flag_i};
  assign stall_o = flag_i[B_STALL_REQ] | flag_i[B_FORCE_STL];

  // R7
  always_comb begin
    wonly_zero_chk: assert (rdata_o[CSR_W-1:NFLAG] == '0);
  end
endmodule

// File: rtl/ep0_ctrl_csr.sv
module ep0_ctrl_csr
  import ep0_csr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_wr_i,
  input  logic [CSR_W-1:0] cpu_wdata_i,
  output logic [CSR_W-1:0] cpu_rdata_o,
  input  logic             rx_done_i,
  input  logic             tx_ack_i,
  input  logic             status_done_i,
  input  logic             setup_tok_i,
  input  logic             setup_abort_i,
  input  logic             proto_err_i,
  output logic             stall_o
);
  ep0_evt_t         evt;
  logic [NFLAG-1:0] set_v, clr_v, flag_q;

  assign evt = '{rx_done:     rx_done_i,
                 tx_ack:      tx_ack_i,
                 status_done: status_done_i,
                 setup_tok:   setup_tok_i,
                 setup_abort: setup_abort_i,
                 proto_err:   proto_err_i};

  ep0_csr_ctrl i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cpu_wr_i),
    .wdata_i (cpu_wdata_i),
    .evt_i   (evt),
    .set_o   (set_v),
    .clr_o   (clr_v)
  );

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    ep0_csr_flag #(.RST_VAL(1'b0)) i_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v[g]),
      .clr_i  (clr_v[g]),
      .q_o    (flag_q[g])
    );
  end

  ep0_csr_read i_read (
    .flag_i  (flag_q),
    .rdata_o (cpu_rdata_o),
    .stall_o (stall_o)
  );

  // R2
  rx_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_i |=> cpu_rdata_o[B_RX_RDY]);

  // R3
  tx_wr0_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && !cpu_wdata_i[B_TX_RDY] && !tx_ack_i && cpu_rdata_o[B_TX_RDY])
      |=> cpu_rdata_o[B_TX_RDY]);

  // R4
  stall_req_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_done_i || setup_tok_i) && !(cpu_wr_i && cpu_wdata_i[B_STALL_REQ]))
      |=> !cpu_rdata_o[B_STALL_REQ]);

  // R5
  force_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && !cpu_wdata_i[B_FORCE_STL] && !proto_err_i) |=> !cpu_rdata_o[B_FORCE_STL]);

  // R6
  early_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_abort_i |=> cpu_rdata_o[B_EARLY_END]);

  // R8
  stall_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> $past((cpu_wr_i && cpu_wdata_i[B_STALL_REQ]) || proto_err_i));
endmodule

// File: tb/test_ep0_ctrl_csr.sv
module test_ep0_ctrl_csr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd;
  logic       rx_done = 0, tx_ack = 0, st_done = 0, setup_tok = 0, abort = 0, perr = 0;
  logic       stall;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  // event mask bits
  localparam logic [5:0] E_RX = 6'h01, E_ACK = 6'h02, E_STD = 6'h04,
                         E_TOK = 6'h08, E_ABT = 6'h10, E_ERR = 6'h20;

  always #4 clk = ~clk;

  ep0_ctrl_csr i_ep0_ctrl_csr (
    .clk_i(clk), .rst_ni(rst_n), .cpu_wr_i(wr), .cpu_wdata_i(wd), .cpu_rdata_o(rd),
    .rx_done_i(rx_done), .tx_ack_i(tx_ack), .status_done_i(st_done),
    .setup_tok_i(setup_tok), .setup_abort_i(abort), .proto_err_i(perr), .stall_o(stall)
  );

  task automatic chk(input string req, input logic [7:0] exp_rd, input logic exp_st);
    checks++;
    if (rd !== exp_rd || stall !== exp_st) begin
      errors++;
      $display("FAIL %s: rdata=%02h stall=%0b expected rdata=%02h stall=%0b",
               req, rd, stall, exp_rd, exp_st);
    end
  endtask

  // drive one cycle of stimulus, returns after the sampling edge, at negedge
  task automatic step(input logic w, input logic [7:0] d, input logic [5:0] ev);
    wr = w; wd = d;
    {perr, abort, setup_tok, st_done, tx_ack, rx_done} = ev;
    @(negedge clk);
    wr = 0; wd = 8'h00;
    {perr, abort, setup_tok, st_done, tx_ack, rx_done} = '0;
  endtask

  task automatic t_reset;
    chk("R1", 8'h00, 1'b0);
  endtask

  task automatic t_rx;
    step(1, 8'h01, 0);       chk("R2 direct write ignored", 8'h00, 0);
    step(0, 8'h00, E_RX);    chk("R2 set", 8'h01, 0);
    step(1, 8'h00, 0);       chk("R2 write 0 ignored", 8'h01, 0);
    wr = 1; wd = 8'h40; #1;  chk("R10 old value in write cycle", 8'h01, 0);
    @(negedge clk); wr = 0; wd = 8'h00;
    chk("R2 service clears", 8'h00, 0);
    step(1, 8'h40, E_RX);    chk("R9 rx set beats service", 8'h01, 0);
    step(1, 8'h40, 0);       chk("R2 clean", 8'h00, 0);
  endtask

  task automatic t_tx;
    step(1, 8'h02, 0);       chk("R3 set", 8'h02, 0);
    step(1, 8'h00, 0);       chk("R3 write 0 ignored", 8'h02, 0);
    step(0, 8'h00, E_ACK);   chk("R3 ack clears", 8'h00, 0);
    step(1, 8'h02, E_ACK);   chk("R3 cpu set beats ack", 8'h02, 0);
    step(0, 8'h00, E_ACK);   chk("R3 clean", 8'h00, 0);
  endtask

  task automatic t_stall;
    step(1, 8'h04, 0);       chk("R4 R8 stall request", 8'h04, 1);
    step(1, 8'h0C, 0);       chk("R4 last data", 8'h0C, 1);
    step(1, 8'h00, 0);       chk("R4 write 0 ignored", 8'h0C, 1);
    step(0, 8'h00, E_STD);   chk("R4 R8 status done clears", 8'h00, 0);
    step(1, 8'h0C, 0);       chk("R4 reset up", 8'h0C, 1);
    step(0, 8'h00, E_TOK);   chk("R4 setup token clears", 8'h00, 0);
    step(1, 8'h04, E_TOK);   chk("R4 cpu set beats token", 8'h04, 1);
    step(0, 8'h00, E_STD);   chk("R4 clean", 8'h00, 0);
  endtask

  task automatic t_force;
    step(0, 8'h00, E_ERR);   chk("R5 R8 forced stall", 8'h10, 1);
    step(1, 8'h10, 0);       chk("R5 write 1 ignored", 8'h10, 1);
    step(1, 8'h00, 0);       chk("R5 write 0 clears", 8'h00, 0);
    step(1, 8'h00, E_ERR);   chk("R9 error beats cpu clear", 8'h10, 1);
    step(1, 8'h14, 0);       chk("R8 both stall sources", 8'h14, 1);
    step(1, 8'h00, E_STD);   chk("R5 clean", 8'h00, 0);
  endtask

  task automatic t_early;
    step(0, 8'h00, E_ABT);   chk("R6 set", 8'h20, 0);
    step(1, 8'h20, 0);       chk("R6 direct write ignored", 8'h20, 0);
    step(1, 8'h80, 0);       chk("R6 service clears", 8'h00, 0);
    step(1, 8'h80, E_ABT);   chk("R9 abort beats service", 8'h20, 0);
    step(1, 8'h80, 0);       chk("R6 clean", 8'h00, 0);
  endtask

  task automatic t_wonly;
    step(0, 8'h00, E_RX | E_ABT);  chk("R2 R6 both flags", 8'h21, 0);
    step(1, 8'hD0, 0);             chk("R7 both services", 8'h00, 0);
    step(1, 8'hFE, 0);             chk("R7 service bits read 0", 8'h0E, 1);
    step(0, 8'h00, E_ACK | E_STD); chk("R3 R4 clean", 8'h00, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rx();
    t_tx();
    t_stall();
    t_force();
    t_early();
    t_wonly();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule